// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block is the home-node directory for a three-state (Modified / Shared / Invalid) cache-coherence protocol. It serves a fixed number of private caches and a directly indexed set of tracked blocks. For every block it holds a coherence state, a bit-vector of caches that share the block, and a one-hot vector that names the single writer. Caches send read requests, write requests and evictions. The directory answers with memory reads, writebacks, invalidations, forwarded requests to the current owner, eviction acknowledgements and data responses.

There are three message inputs: cache requests, cache data responses and memory replies. There are three message outputs: the forward channel, the data-response channel and the memory-command channel. Every port uses a valid/ready handshake. Memory latency is unknown to the directory, so a block that waits on memory or on an owner sits in a transient state. A read or write request for such a block is held at the head of the request input. The other two inputs keep draining while it is held, so the transient state can always resolve.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset every block is Invalid with no sharers and no owner, and no output channel shows valid.
- R2: A read request (req_type 0) for a block in I or S issues a memory read (mcmd_write 0) and adds the requester as a sharer. When the memory data arrives (mem_rsp_is_ack 0), the data goes to the requester on the data-response channel with an ack count of 0, and the block becomes S.
- R3: A write request (req_type 1) for a block in I issues a memory read and records the requester as owner. The later data response carries an ack count of 0 and sends no invalidate.
- R4: A write request for a block in S removes the requester from the sharers. It sends one invalidate (fwd_type 0) whose fwd_dest bit-vector lists the remaining sharers, and sends none when no sharer remains. It also issues a memory read. The data response carries the number of remaining sharers as its ack count.
- R5: A read request for a block in M forwards a read (fwd_type 1) to the owner. Both the requester and the old owner become sharers. The owner's data response is then written to memory (mcmd_write 1). After the memory write acknowledgement (mem_rsp_is_ack 1), the block is back in S.
- R6: A write request for a block in M forwards a write (fwd_type 2) to the old owner, makes the requester the owner and issues no memory command.
- R7: An eviction with data (req_type 3) from the recorded owner of a block in M writes its data to memory and sends an eviction acknowledgement (fwd_type 3). After the memory write acknowledgement, the block is Invalid.
- R8: A clean eviction (req_type 2) that is not from the last sharer, and an eviction with data from a cache that is not the owner, are each acknowledged (fwd_type 3) to the sender. The sender is removed from the sharers, and ownership does not change.
- R9: A clean eviction from the only sharer of a block in S leaves the block with no sharers. A later write request gets no invalidate and an ack count of 0.
- R10: A read or write request for a block in a transient state is not accepted (req_ready stays low). Cache data responses and memory replies are still accepted while it waits.
- R11: At most one message is consumed per cycle. Memory replies win over cache responses, and cache responses win over requests.
- R12: A memory command shows valid MEM_LAT cycles (1 by default) after the edge that consumed its trigger. It holds its value while mcmd_ready is low. No further message that needs a memory command is accepted until the command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cache request valid |
| req_ready | output | 1 | Cache request accepted |
| req_type | input | 2 | 0 read, 1 write, 2 clean eviction, 3 eviction with data |
| req_src | input | CW | Requesting cache index |
| req_blk | input | BW | Block index |
| req_data | input | DW | Eviction data |
| rsp_in_valid | input | 1 | Owner data response valid |
| rsp_in_ready | output | 1 | Owner data response accepted |
| rsp_in_blk | input | BW | Block index of owner data |
| rsp_in_data | input | DW | Owner data |
| mem_rsp_valid | input | 1 | Memory reply valid |
| mem_rsp_ready | output | 1 | Memory reply accepted |
| mem_rsp_is_ack | input | 1 | 1 write acknowledgement, 0 read data |
| mem_rsp_blk | input | BW | Block index of reply |
| mem_rsp_data | input | DW | Read data |
| mem_rsp_dst | input | CW | Cache that caused the read |
| fwd_valid | output | 1 | Forward-channel message valid |
| fwd_ready | input | 1 | Forward channel accepts |
| fwd_type | output | 2 | 0 invalidate, 1 forwarded read, 2 forwarded write, 3 eviction ack |
| fwd_dest | output | NC | Destination caches, bit-vector |
| fwd_req | output | CW | Cache whose request caused the message |
| fwd_blk | output | BW | Block index |
| drsp_valid | output | 1 | Data response valid |
| drsp_ready | input | 1 | Data response accepted |
| drsp_dest | output | CW | Destination cache |
| drsp_blk | output | BW | Block index |
| drsp_data | output | DW | Block data |
| drsp_acks | output | AW | Invalidation acks the receiver must collect |
| mcmd_valid | output | 1 | Memory command valid |
| mcmd_ready | input | 1 | Memory accepts command |
| mcmd_write | output | 1 | 1 write, 0 read |
| mcmd_blk | output | BW | Block index |
| mcmd_data | output | DW | Write data |
| mcmd_src | output | CW | Cache to echo back on the reply |

## Verification
Some properties are checked on every cycle. At most one input is consumed per cycle, and a memory reply blocks the other inputs. A read or write request aimed at a transient block is never accepted. Any entry written as M has exactly one owner and no sharers, and any entry written as I is empty. A waiting memory command holds steady, and a data response only goes out together with memory read data.

Other behaviour can only be shown by the scenarios. These cover the invalidate destination sets and ack counts, and owner forwarding and replacement. They also cover the transient sequences S_D to SS_m to S and MI_m to I, classification of evictions as last sharer or owner, and release of a held request once its block settles.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

    typedef enum logic [2:0] {
        ST_I   = 3'd0,
        ST_S   = 3'd1,
        ST_M   = 3'd2,
        ST_SD  = 3'd3,
        ST_SM  = 3'd4,
        ST_MM  = 3'd5,
        ST_MIM = 3'd6,
        ST_SSM = 3'd7
    } dir_state_e;

    typedef enum logic [1:0] {
        RQ_GETS = 2'd0,
        RQ_GETM = 2'd1,
        RQ_PUTS = 2'd2,
        RQ_PUTM = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        FW_INV    = 2'd0,
        FW_GETS   = 2'd1,
        FW_GETM   = 2'd2,
        FW_PUTACK = 2'd3
    } fwd_kind_e;

    localparam int unsigned SRC_MEM = 0;
    localparam int unsigned SRC_RSP = 1;
    localparam int unsigned SRC_REQ = 2;
    localparam int unsigned NUM_SRC = 3;

    function automatic logic is_transient(dir_state_e s);
        return !(s == ST_I || s == ST_S || s == ST_M);
    endfunction

    function automatic logic is_get(logic [1:0] k);
        return (k == RQ_GETS) || (k == RQ_GETM);
    endfunction

endpackage

// File: rtl/msi_dir_arbiter.sv
module msi_dir_arbiter #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] reqs,
    output logic [N-1:0] grant
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_prio
            assign grant[g]  = reqs[g] & ~seen[g];
            assign seen[g+1] = seen[g] | reqs[g];
        end
    endgenerate
endmodule

// File: rtl/msi_dir_store.sv
module msi_dir_store
    import msi_dir_pkg::*;
#(
    parameter int unsigned NB = 16,
    parameter int unsigned NC = 4,
    localparam int unsigned BW = $clog2(NB)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [BW-1:0] rd_idx,
    output dir_state_e rd_state,
    output logic [NC-1:0] rd_shr,
    output logic [NC-1:0] rd_own,
    input  logic       we,
    input  logic [BW-1:0] wr_idx,
    input  dir_state_e wr_state,
    input  logic [NC-1:0] wr_shr,
    input  logic [NC-1:0] wr_own
);
    dir_state_e    st_q  [NB];
    logic [NC-1:0] shr_q [NB];
    logic [NC-1:0] own_q [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) begin
                st_q[i]  <= ST_I;
                shr_q[i] <= '0;
                own_q[i] <= '0;
            end
        end else if (we) begin
            st_q[wr_idx]  <= wr_state;
            shr_q[wr_idx] <= wr_shr;
            own_q[wr_idx] <= wr_own;
        end
    end

    assign rd_state = st_q[rd_idx];
    assign rd_shr   = shr_q[rd_idx];
    assign rd_own   = own_q[rd_idx];

    a_r1_invalid_empty: assert property (@(posedge clk) disable iff (rst)
        (we && wr_state == ST_I) |-> (wr_shr == '0 && wr_own == '0));

    a_r6_single_writer: assert property (@(posedge clk) disable iff (rst)
        (we && wr_state == ST_M) |-> ($onehot(wr_own) && wr_shr == '0));
endmodule

// File: rtl/msi_dir_memslot.sv
module msi_dir_memslot #(
    parameter int unsigned W   = 8,
    parameter int unsigned LAT = 1,
    localparam int unsigned CNTW = (LAT < 2) ? 1 : $clog2(LAT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] cmd_in,
    output logic         free,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] cmd_out
);
    logic            full_q;
    logic [CNTW-1:0] cnt_q;
    logic [W-1:0]    cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (load) begin
            full_q <= 1'b1;
            cnt_q  <= CNTW'(LAT - 1);
            cmd_q  <= cmd_in;
        end else if (full_q) begin
            if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            else if (out_ready)
                full_q <= 1'b0;
        end
    end

    assign free      = ~full_q;
    assign out_valid = full_q && (cnt_q == '0);
    assign cmd_out   = cmd_q;

    a_r12_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(cmd_out)));
endmodule

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl
    import msi_dir_pkg::*;
#(
    parameter int unsigned NC      = 4,
    parameter int unsigned NB      = 16,
    parameter int unsigned DW      = 32,
    parameter int unsigned MEM_LAT = 1,
    localparam int unsigned CW = (NC < 2) ? 1 : $clog2(NC),
    localparam int unsigned BW = (NB < 2) ? 1 : $clog2(NB),
    localparam int unsigned AW = $clog2(NC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_type,
    input  logic [CW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    input  logic          rsp_in_valid,
    output logic          rsp_in_ready,
    input  logic [BW-1:0] rsp_in_blk,
    input  logic [DW-1:0] rsp_in_data,
    input  logic          mem_rsp_valid,
    output logic          mem_rsp_ready,
    input  logic          mem_rsp_is_ack,
    input  logic [BW-1:0] mem_rsp_blk,
    input  logic [DW-1:0] mem_rsp_data,
    input  logic [CW-1:0] mem_rsp_dst,
    output logic          fwd_valid,
    input  logic          fwd_ready,
    output logic [1:0]    fwd_type,
    output logic [NC-1:0] fwd_dest,
    output logic [CW-1:0] fwd_req,
    output logic [BW-1:0] fwd_blk,
    output logic          drsp_valid,
    input  logic          drsp_ready,
    output logic [CW-1:0] drsp_dest,
    output logic [BW-1:0] drsp_blk,
    output logic [DW-1:0] drsp_data,
    output logic [AW-1:0] drsp_acks,
    output logic          mcmd_valid,
    input  logic          mcmd_ready,
    output logic          mcmd_write,
    output logic [BW-1:0] mcmd_blk,
    output logic [DW-1:0] mcmd_data,
    output logic [CW-1:0] mcmd_src
);
    localparam int unsigned MW = 1 + BW + DW + CW;

    logic [NUM_SRC-1:0] vld, grant;
    assign vld[SRC_MEM] = mem_rsp_valid;
    assign vld[SRC_RSP] = rsp_in_valid;
    assign vld[SRC_REQ] = req_valid;

    msi_dir_arbiter #(.N(NUM_SRC)) u_arb (.reqs(vld), .grant(grant));

    logic [BW-1:0] sel_blk;
    always_comb begin
        if (grant[SRC_MEM])      sel_blk = mem_rsp_blk;
        else if (grant[SRC_RSP]) sel_blk = rsp_in_blk;
        else                     sel_blk = req_blk;
    end

    dir_state_e    cur_st, st_n;
    logic [NC-1:0] cur_shr, cur_own, shr_n, own_n;
    logic          go;

    msi_dir_store #(.NB(NB), .NC(NC)) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(sel_blk), .rd_state(cur_st), .rd_shr(cur_shr), .rd_own(cur_own),
        .we(go), .wr_idx(sel_blk), .wr_state(st_n), .wr_shr(shr_n), .wr_own(own_n)
    );

    // per-message action decode
    logic          stall, need_fwd, need_drsp, need_mem, mem_wr;
    fwd_kind_e     fk;
    logic [NC-1:0] fdest;
    logic [DW-1:0] mdata;
    logic [CW-1:0] msrc;
    logic [AW-1:0] acks;
    logic [NC-1:0] req_oh, others;
    logic          slot_free;

    assign req_oh = NC'(1) << req_src;
    assign others = cur_shr & ~req_oh;

    always_comb begin
        st_n      = cur_st;
        shr_n     = cur_shr;
        own_n     = cur_own;
        stall     = 1'b0;
        need_fwd  = 1'b0;
        need_drsp = 1'b0;
        need_mem  = 1'b0;
        mem_wr    = 1'b0;
        fk        = FW_PUTACK;
        fdest     = req_oh;
        mdata     = req_data;
        msrc      = req_src;
        acks      = cur_own[mem_rsp_dst] ? AW'($countones(cur_shr)) : '0;

        if (grant[SRC_MEM]) begin
            if (!mem_rsp_is_ack) begin
                if (cur_st == ST_SM) begin
                    need_drsp = 1'b1;
                    st_n      = ST_S;
                end else if (cur_st == ST_MM) begin
                    need_drsp = 1'b1;
                    shr_n     = '0;
                    st_n      = ST_M;
                end
            end else begin
                if (cur_st == ST_MIM)      st_n = ST_I;
                else if (cur_st == ST_SSM) st_n = ST_S;
            end
        end else if (grant[SRC_RSP]) begin
            if (cur_st == ST_SD) begin
                need_mem = 1'b1;
                mem_wr   = 1'b1;
                mdata    = rsp_in_data;
                msrc     = '0;
                st_n     = ST_SSM;
            end
        end else if (grant[SRC_REQ]) begin
            unique case (req_type)
                RQ_GETS: begin
                    if (cur_st == ST_I || cur_st == ST_S) begin
                        need_mem = 1'b1;
                        shr_n    = cur_shr | req_oh;
                        st_n     = ST_SM;
                    end else if (cur_st == ST_M) begin
                        need_fwd = 1'b1;
                        fk       = FW_GETS;
                        fdest    = cur_own;
                        shr_n    = cur_shr | cur_own | req_oh;
                        own_n    = '0;
                        st_n     = ST_SD;
                    end else begin
                        stall = 1'b1;
                    end
                end
                RQ_GETM: begin
                    if (cur_st == ST_I || cur_st == ST_S) begin
                        need_mem = 1'b1;
                        own_n    = req_oh;
                        shr_n    = others;
                        st_n     = ST_MM;
                        if (cur_st == ST_S && others != '0) begin
                            need_fwd = 1'b1;
                            fk       = FW_INV;
                            fdest    = others;
                        end
                    end else if (cur_st == ST_M) begin
                        need_fwd = 1'b1;
                        fk       = FW_GETM;
                        fdest    = cur_own;
                        own_n    = req_oh;
                    end else begin
                        stall = 1'b1;
                    end
                end
                RQ_PUTS: begin
                    need_fwd = 1'b1;
                    if (cur_st inside {ST_S, ST_SD, ST_SM, ST_SSM}) begin
                        shr_n = others;
                        if (cur_st == ST_S && cur_shr == req_oh)
                            st_n = ST_I;
                    end
                end
                RQ_PUTM: begin
                    if (cur_own[req_src]) begin
                        if (cur_st == ST_M) begin
                            need_fwd = 1'b1;
                            need_mem = 1'b1;
                            mem_wr   = 1'b1;
                            own_n    = '0;
                            st_n     = ST_MIM;
                        end else begin
                            stall = 1'b1;
                        end
                    end else begin
                        need_fwd = 1'b1;
                        if (cur_st inside {ST_S, ST_SD, ST_SM, ST_SSM})
                            shr_n = others;
                    end
                end
                default: stall = 1'b1;
            endcase
        end
    end

    assign go = (|vld) && !stall
             && (!need_fwd  || fwd_ready)
             && (!need_drsp || drsp_ready)
             && (!need_mem  || slot_free);

    assign mem_rsp_ready = grant[SRC_MEM] && go;
    assign rsp_in_ready  = grant[SRC_RSP] && go;
    assign req_ready     = grant[SRC_REQ] && go;

    assign fwd_valid = need_fwd && (!need_mem || slot_free);
    assign fwd_type  = fk;
    assign fwd_dest  = fdest;
    assign fwd_req   = req_src;
    assign fwd_blk   = req_blk;

    assign drsp_valid = need_drsp;
    assign drsp_dest  = mem_rsp_dst;
    assign drsp_blk   = mem_rsp_blk;
    assign drsp_data  = mem_rsp_data;
    assign drsp_acks  = acks;

    logic [MW-1:0] slot_out;
    msi_dir_memslot #(.W(MW), .LAT(MEM_LAT)) u_slot (
        .clk(clk), .rst(rst),
        .load(go && need_mem),
        .cmd_in({mem_wr, sel_blk, mdata, msrc}),
        .free(slot_free),
        .out_valid(mcmd_valid), .out_ready(mcmd_ready),
        .cmd_out(slot_out)
    );
    assign {mcmd_write, mcmd_blk, mcmd_data, mcmd_src} = slot_out;

    a_r11_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
        $countones({req_valid && req_ready, rsp_in_valid && rsp_in_ready,
                    mem_rsp_valid && mem_rsp_ready}) <= 1);

    a_r11_memory_first: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid |-> (!req_ready && !rsp_in_ready));

    a_r10_hold_transient: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_rsp_valid && !rsp_in_valid && is_get(req_type)
         && is_transient(cur_st)) |-> !req_ready);

    a_r2_data_from_memory: assert property (@(posedge clk) disable iff (rst)
        drsp_valid |-> (mem_rsp_valid && !mem_rsp_is_ack));
endmodule

// File: tb/msi_dir_ctrl_tb.sv
`timescale 1ns/1ps
module msi_dir_ctrl_tb;
    localparam int NC = 4, NB = 16, DW = 32;
    localparam int CW = 2, BW = 4, AW = 3;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, rsp_in_valid = 0, mem_rsp_valid = 0, mem_rsp_is_ack = 0;
    logic          req_ready, rsp_in_ready, mem_rsp_ready;
    logic [1:0]    req_type = 0;
    logic [CW-1:0] req_src = 0, mem_rsp_dst = 0;
    logic [BW-1:0] req_blk = 0, rsp_in_blk = 0, mem_rsp_blk = 0;
    logic [DW-1:0] req_data = 0, rsp_in_data = 0, mem_rsp_data = 0;
    logic          fwd_valid, drsp_valid, mcmd_valid, mcmd_write;
    logic          fwd_ready = 1, drsp_ready = 1, mcmd_ready = 1;
    logic [1:0]    fwd_type;
    logic [NC-1:0] fwd_dest;
    logic [CW-1:0] fwd_req, drsp_dest, mcmd_src;
    logic [BW-1:0] fwd_blk, drsp_blk, mcmd_blk;
    logic [DW-1:0] drsp_data, mcmd_data;
    logic [AW-1:0] drsp_acks;

    msi_dir_ctrl u_dut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // handshake monitors
    int f_n = 0, d_n = 0, m_n = 0, m_seen = 0;
    logic [1:0] lf_type; logic [NC-1:0] lf_dest; logic [CW-1:0] lf_req;
    logic [CW-1:0] ld_dest; logic [DW-1:0] ld_data; logic [AW-1:0] ld_acks;
    logic lm_wr; logic [BW-1:0] lm_blk; logic [DW-1:0] lm_data; logic [CW-1:0] lm_src;

    always @(negedge clk) begin
        if (!rst && fwd_valid && fwd_ready) begin
            f_n++; lf_type = fwd_type; lf_dest = fwd_dest; lf_req = fwd_req;
        end
        if (!rst && drsp_valid && drsp_ready) begin
            d_n++; ld_dest = drsp_dest; ld_data = drsp_data; ld_acks = drsp_acks;
        end
        if (!rst && mcmd_valid && mcmd_ready) begin
            m_n++; lm_wr = mcmd_write; lm_blk = mcmd_blk; lm_data = mcmd_data; lm_src = mcmd_src;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_req(input int kind, input int src, input int blk,
                            input logic [DW-1:0] d, input string tag);
        bit got = 0;
        req_valid = 1; req_type = kind[1:0]; req_src = src[CW-1:0];
        req_blk = blk[BW-1:0]; req_data = d;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (req_ready) begin got = 1; break; end
        end
        if (!got) chk({tag, " request accepted"}, 0, 1);
        tick();
        req_valid = 0;
    endtask

    task automatic mem_reply(input logic ack, input int blk, input logic [DW-1:0] d, input int dst);
        bit got = 0;
        mem_rsp_valid = 1; mem_rsp_is_ack = ack; mem_rsp_blk = blk[BW-1:0];
        mem_rsp_data = d; mem_rsp_dst = dst[CW-1:0];
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (mem_rsp_ready) begin got = 1; break; end
        end
        if (!got) chk("R10 memory reply accepted", 0, 1);
        tick();
        mem_rsp_valid = 0;
    endtask

    task automatic cache_data(input int blk, input logic [DW-1:0] d);
        bit got = 0;
        rsp_in_valid = 1; rsp_in_blk = blk[BW-1:0]; rsp_in_data = d;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rsp_in_ready) begin got = 1; break; end
        end
        if (!got) chk("R10 cache data accepted", 0, 1);
        tick();
        rsp_in_valid = 0;
    endtask

    task automatic wait_mcmd(input string tag);
        for (int i = 0; i < 20 && m_n == m_seen; i++) tick();
        chk({tag, " memory command seen"}, (m_n > m_seen), 1);
        m_seen = m_n;
    endtask

    // waits for a read command on blk, answers it, checks the data response
    task automatic serve_read(input int blk, input logic [DW-1:0] d, input int dest,
                              input int exp_acks, input string tag);
        int d0 = d_n;
        wait_mcmd(tag);
        chk({tag, " read cmd"}, {lm_wr, lm_blk}, {1'b0, 4'(blk)});
        mem_reply(0, blk, d, int'(lm_src));
        chk({tag, " data rsp"}, {32'(d_n - d0), 30'(ld_dest), ld_data},
            {32'd1, 30'(dest), d});
        chk({tag, " ack count"}, ld_acks, exp_acks);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 outputs idle after reset", {fwd_valid, drsp_valid, mcmd_valid}, 3'b000);
    endtask

    task automatic t_read_from_invalid();
        send_req(0, 0, 3, 0, "R2");
        chk("R12 command one cycle after trigger", mcmd_valid, 1);
        serve_read(3, 32'hA5, 0, 0, "R2 first read");
        send_req(0, 1, 3, 0, "R2");
        serve_read(3, 32'hB6, 1, 0, "R2 read in S");
    endtask

    task automatic t_write_from_shared();
        int f0 = f_n;
        send_req(1, 2, 3, 0, "R4");
        chk("R4 invalidate", {32'(f_n - f0), 30'(lf_type), 28'(lf_dest), 30'(lf_req)},
            {32'd1, 30'd0, 28'b0011, 30'd2});
        serve_read(3, 32'hC7, 2, 2, "R4 upgrade");
    endtask

    task automatic t_write_in_modified();
        int f0 = f_n; int m0 = m_n;
        send_req(1, 3, 3, 0, "R6");
        chk("R6 forwarded write", {32'(f_n - f0), 30'(lf_type), 28'(lf_dest), 30'(lf_req)},
            {32'd1, 30'd2, 28'b0100, 30'd3});
        tick(); tick();
        chk("R6 no memory command", m_n - m0, 0);
    endtask

    task automatic t_read_in_modified_and_stall();
        int f0 = f_n; bit held = 1; bit got = 0;
        send_req(0, 0, 3, 0, "R5");
        chk("R5 forwarded read", {32'(f_n - f0), 30'(lf_type), 28'(lf_dest)},
            {32'd1, 30'd1, 28'b1000});
        // write request now targets a block waiting on owner data
        req_valid = 1; req_type = 2'd1; req_src = 2'd1; req_blk = 4'd3;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (req_ready) held = 0;
        end
        chk("R10 request held in S_D", held, 1);
        tick();
        cache_data(3, 32'h77);
        wait_mcmd("R5");
        chk("R5 owner data written", {lm_wr, lm_blk, lm_data}, {1'b1, 4'd3, 32'h77});
        @(negedge clk);
        chk("R10 request held in SS_m", req_ready, 0);
        tick();
        f0 = f_n;
        mem_reply(1, 3, 0, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_ready) begin got = 1; break; end
        end
        chk("R5 back in S releases request", got, 1);
        tick();
        req_valid = 0;
        chk("R5 sharers are requester and old owner",
            {32'(f_n - f0), 30'(lf_type), 28'(lf_dest)}, {32'd1, 30'd0, 28'b1001});
        serve_read(3, 32'h11, 1, 2, "R4 after S_D");
    endtask

    task automatic t_owner_writeback();
        int f0 = f_n;
        send_req(3, 1, 3, 32'h3C, "R7");
        chk("R7 put ack", {32'(f_n - f0), 30'(lf_type), 28'(lf_dest)},
            {32'd1, 30'd3, 28'b0010});
        wait_mcmd("R7");
        chk("R7 writeback", {lm_wr, lm_blk, lm_data}, {1'b1, 4'd3, 32'h3C});
        mem_reply(1, 3, 0, 0);
        f0 = f_n;
        send_req(1, 2, 3, 0, "R3");
        chk("R3 no invalidate from I", f_n - f0, 0);
        serve_read(3, 32'h21, 2, 0, "R3 write from I");
    endtask

    task automatic t_priority();
        req_valid = 1; req_type = 2'd0; req_src = 2'd0; req_blk = 4'd5;
        mem_rsp_valid = 1; mem_rsp_is_ack = 1; mem_rsp_blk = 4'd9;
        @(negedge clk);
        chk("R11 memory reply wins", {mem_rsp_ready, req_ready}, 2'b10);
        tick();
        mem_rsp_valid = 0;
        @(negedge clk);
        chk("R11 request follows", req_ready, 1);
        tick();
        req_valid = 0;
        serve_read(5, 32'h55, 0, 0, "R2 after priority");
    endtask

    task automatic t_mem_backpressure();
        bit steady = 1; bit got = 0;
        mcmd_ready = 0;
        send_req(0, 1, 5, 0, "R12");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!(mcmd_valid && mcmd_blk == 4'd5 && mcmd_write == 0)) steady = 0;
        end
        chk("R12 command holds under back-pressure", steady, 1);
        tick();
        req_valid = 1; req_type = 2'd1; req_src = 2'd2; req_blk = 4'd6;
        @(negedge clk);
        chk("R12 no second memory trigger while slot full", req_ready, 0);
        tick();
        mcmd_ready = 1;
        wait_mcmd("R12");
        chk("R12 released command", lm_blk, 5);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_ready) begin got = 1; break; end
        end
        chk("R12 trigger accepted after drain", got, 1);
        tick();
        req_valid = 0;
        serve_read(6, 32'h66, 2, 0, "R3 block 6");
        mem_reply(0, 5, 32'h56, 1);
        chk("R2 second sharer data", {30'(ld_dest), ld_data}, {30'd1, 32'h56});
    endtask

    task automatic t_puts();
        int f0;
        send_req(0, 0, 8, 0, "R8");
        serve_read(8, 32'h80, 0, 0, "R8 fill 0");
        send_req(0, 1, 8, 0, "R8");
        serve_read(8, 32'h81, 1, 0, "R8 fill 1");
        send_req(2, 2, 8, 0, "R8");
        chk("R8 ack to non-sharer", {30'(lf_type), 28'(lf_dest)}, {30'd3, 28'b0100});
        send_req(2, 0, 8, 0, "R8");
        chk("R8 ack to sharer", {30'(lf_type), 28'(lf_dest)}, {30'd3, 28'b0001});
        send_req(3, 3, 8, 0, "R8");
        chk("R8 ack to non-owner", {30'(lf_type), 28'(lf_dest)}, {30'd3, 28'b1000});
        f0 = f_n;
        send_req(1, 2, 8, 0, "R8");
        chk("R8 only remaining sharer invalidated",
            {32'(f_n - f0), 30'(lf_type), 28'(lf_dest)}, {32'd1, 30'd0, 28'b0010});
        serve_read(8, 32'h82, 2, 1, "R8 upgrade");
        // last sharer leaves
        send_req(0, 0, 7, 0, "R9");
        serve_read(7, 32'h70, 0, 0, "R9 fill");
        send_req(2, 0, 7, 0, "R9");
        chk("R9 last sharer acked", {30'(lf_type), 28'(lf_dest)}, {30'd3, 28'b0001});
        f0 = f_n;
        send_req(1, 1, 7, 0, "R9");
        chk("R9 no invalidate after last sharer", f_n - f0, 0);
        serve_read(7, 32'h71, 1, 0, "R9 write");
    endtask

    initial begin
        repeat (4) tick();
        rst = 0;
        t_reset();
        tick();
        t_read_from_invalid();
        t_write_from_shared();
        t_write_in_modified();
        t_read_in_modified_and_stall();
        t_owner_writeback();
        t_priority();
        t_mem_backpressure();
        t_puts();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule